// File: doc/BRIEF.md
# Bitslip Receive Word Aligner

This block sits behind a deserializer in the recovered receive clock domain. It takes one parallel word per clock and moves the word boundary by one bit each time a slip is requested. Bit 0 of each input word is the earliest received bit. Each slip drops the oldest bit still in the output window, so the output word takes one newer bit in its place.

The slip request comes from another clock domain. It is brought into the receive domain by a two-flop synchronizer, and an edge detector then turns each rising edge into a single slip. Slipping only happens while the bitslip mode input is high. The block reports the total number of bits slipped so far, so that higher layers can work out the deterministic latency of the link. A separate monitor follows the incoming serial stream and flags words that contain a run of identical bits longer than a configured limit.

Top module: `bitslip_aligner`

## Requirements
- R1: Each rising edge of `slipReq` moves the word boundary by exactly one bit. Holding `slipReq` high for any number of cycles gives only one slip.
- R2: The bits of the input stream are numbered in arrival order, with bit 0 of each word earliest. When the slip count is s, `dataOut` holds the W consecutive stream bits that start s bits after the start of a word. For s = 1 this is {newer word bit 0, older word bits W-1..1}.
- R3: `slipReq` passes through two synchronizer flops and then an edge detector. If `slipReq` is first sampled high at clock edge k, `slipCount` changes after edge k+2 and not earlier.
- R4: `slipCount` (SLIP_W bits, 5 by default) reports the number of slips accepted since reset, counted modulo WORD_W. It changes only when a slip is accepted.
- R5: When `slipCount` is WORD_W-1, the next accepted slip sets it to 0 and the boundary goes back to its original offset. `slipCount` never reaches WORD_W.
- R6: While `bitslipEn` is low, slip request edges are ignored, and `slipCount` and the output alignment stay unchanged.
- R7: `runErr` is high for the one cycle after edge k exactly when the word sampled at edge k ends a run of more than RUN_LIMIT identical bits. Runs continue across word boundaries, and any change of bit value restarts the run.
- R8: With slip count 0, the word sampled at clock edge k appears unchanged on `dataOut` after edge k+2.
- R9: A synchronous active-high `rst` clears the slip count, the word history, the run-length state, the synchronizer and the outputs. After a reset edge, `slipCount`, `runErr` and `dataOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rxWord | input | WORD_W | Parallel word from the deserializer, bit 0 earliest |
| slipReq | input | 1 | Asynchronous slip request; each rising edge asks for one slip |
| bitslipEn | input | 1 | High selects bitslip mode; while low, slip requests are ignored |
| dataOut | output | WORD_W | Realigned output word |
| slipCount | output | SLIP_W | Total bits slipped, modulo WORD_W |
| runErr | output | 1 | One-cycle flag for a word that contains a run-length violation |

## Verification
A slip can take effect in the same cycle that the run-length monitor sees a violating word. When that happens, the barrel select changes while the history shifts and the run counter crosses a word boundary. The random phase provokes this by sending all-ones and all-zeros words while it issues slip requests, toggles the mode input and leaves the request gaps short. A behavioural model compares `dataOut`, `slipCount` and `runErr` against the design on every clock. The model works from a plain two-word window and an unbounded run counter, so a slip and a violation in the same cycle are each judged independently.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  // Strobes from the control path to the datapath, valid for one cycle
  typedef struct packed {
    logic slipStep;   // one accepted slip in this cycle
    logic wrapStep;   // the accepted slip returns the offset to zero
  } slip_strobe_t;

endpackage

// File: rtl/bsa_sync.sv
module bsa_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= asyncIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/bsa_ctrl.sv
module bsa_ctrl
  import bsa_pkg::*;
#(
  parameter int WORD_W      = 20,
  parameter int SLIP_W      = $clog2(WORD_W),
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slipReq,
  input  logic              bitslipEn,
  output slip_strobe_t      strobe,
  output logic [SLIP_W-1:0] slipCnt
);

  localparam logic [SLIP_W-1:0] LAST_OFS = SLIP_W'(WORD_W - 1);

  logic reqSync;
  logic reqLast;
  logic reqRise;

  bsa_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn (slipReq),
    .syncOut (reqSync)
  );

  // Edge detector: a held level yields a single pulse
  always_ff @(posedge clk) begin
    if (rst) reqLast <= 1'b0;
    else     reqLast <= reqSync;
  end

  assign reqRise = reqSync & ~reqLast;

  always_comb begin
    strobe.slipStep = reqRise & bitslipEn;
    strobe.wrapStep = strobe.slipStep & (slipCnt == LAST_OFS);
  end

  // Cumulative slip counter, modulo WORD_W
  always_ff @(posedge clk) begin
    if (rst)                  slipCnt <= '0;
    else if (strobe.wrapStep) slipCnt <= '0;
    else if (strobe.slipStep) slipCnt <= slipCnt + 1'b1;
  end

endmodule

// File: rtl/bsa_datapath.sv
module bsa_datapath
  import bsa_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int SLIP_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] rxWord,
  input  slip_strobe_t      strobe,
  output logic [WORD_W-1:0] dataOut,
  output logic [SLIP_W-1:0] selOfs
);

  localparam int IDX_W = $clog2(2 * WORD_W);

  logic [WORD_W-1:0]   histNew;
  logic [WORD_W-1:0]   histOld;
  logic [2*WORD_W-1:0] window;
  logic [WORD_W-1:0]   picked;

  // Two-word history; the newer word sits in the upper half of the window
  always_ff @(posedge clk) begin
    if (rst) begin
      histNew <= '0;
      histOld <= '0;
    end else begin
      histNew <= rxWord;
      histOld <= histNew;
    end
  end

  assign window = {histNew, histOld};

  // Barrel offset, advanced only by the control strobes
  always_ff @(posedge clk) begin
    if (rst)                  selOfs <= '0;
    else if (strobe.wrapStep) selOfs <= '0;
    else if (strobe.slipStep) selOfs <= selOfs + 1'b1;
  end

  // One multiplexer per output bit
  generate
    for (genvar j = 0; j < WORD_W; j++) begin : g_pick
      logic [IDX_W-1:0] idx;
      assign idx       = IDX_W'(selOfs) + IDX_W'(j);
      assign picked[j] = window[idx];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) dataOut <= '0;
    else     dataOut <= picked;
  end

endmodule

// File: rtl/bsa_runlen.sv
module bsa_runlen #(
  parameter int WORD_W    = 20,
  parameter int RUN_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] rxWord,
  output logic              runErr
);

  localparam int             RL_W = $clog2(RUN_LIMIT + 2);
  localparam logic [RL_W-1:0] CAP = RL_W'(RUN_LIMIT + 1);

  logic [RL_W-1:0] runCnt;
  logic            lastBit;
  logic [RL_W-1:0] cntNext;
  logic            bitNext;
  logic            violNext;

  // Walk the word in arrival order; the run carries across word edges
  always_comb begin
    cntNext  = runCnt;
    bitNext  = lastBit;
    violNext = 1'b0;
    for (int i = 0; i < WORD_W; i++) begin
      if (cntNext != '0 && rxWord[i] == bitNext) begin
        if (cntNext != CAP) cntNext = cntNext + 1'b1;
      end else begin
        cntNext = RL_W'(1);
        bitNext = rxWord[i];
      end
      if (cntNext == CAP) violNext = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      runCnt  <= '0;
      lastBit <= 1'b0;
      runErr  <= 1'b0;
    end else begin
      runCnt  <= cntNext;
      lastBit <= bitNext;
      runErr  <= violNext;
    end
  end

endmodule

// File: rtl/bitslip_aligner.sv
module bitslip_aligner
  import bsa_pkg::*;
#(
  parameter int WORD_W      = 20,
  parameter int RUN_LIMIT   = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SLIP_W      = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] rxWord,
  input  logic              slipReq,
  input  logic              bitslipEn,
  output logic [WORD_W-1:0] dataOut,
  output logic [SLIP_W-1:0] slipCount,
  output logic              runErr
);

  slip_strobe_t      strobe;
  logic [SLIP_W-1:0] dpSel;

  bsa_ctrl #(
    .WORD_W      (WORD_W),
    .SLIP_W      (SLIP_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .slipReq   (slipReq),
    .bitslipEn (bitslipEn),
    .strobe    (strobe),
    .slipCnt   (slipCount)
  );

  bsa_datapath #(
    .WORD_W (WORD_W),
    .SLIP_W (SLIP_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .rxWord  (rxWord),
    .strobe  (strobe),
    .dataOut (dataOut),
    .selOfs  (dpSel)
  );

  bsa_runlen #(
    .WORD_W    (WORD_W),
    .RUN_LIMIT (RUN_LIMIT)
  ) u_rl (
    .clk    (clk),
    .rst    (rst),
    .rxWord (rxWord),
    .runErr (runErr)
  );

endmodule

// File: rtl/bitslip_aligner_chk.sv
module bitslip_aligner_chk #(
  parameter int WORD_W    = 20,
  parameter int RUN_LIMIT = 16,
  parameter int SLIP_W    = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              bitslipEn,
  input logic [WORD_W-1:0] rxWord,
  input logic [WORD_W-1:0] dataOut,
  input logic [SLIP_W-1:0] slipCount,
  input logic              runErr,
  input logic              slipStep,
  input logic              wrapStep,
  input logic [SLIP_W-1:0] dpSel
);

  localparam logic [SLIP_W-1:0] LAST_OFS = SLIP_W'(WORD_W - 1);

  p_single_step_r1: assert property (@(posedge clk) disable iff (rst)
    slipStep |=> !slipStep);

  p_sel_agree_r2: assert property (@(posedge clk) disable iff (rst)
    dpSel == slipCount);

  p_count_advance_r4: assert property (@(posedge clk) disable iff (rst)
    slipStep |=> slipCount == (($past(slipCount) == LAST_OFS) ? '0 : $past(slipCount) + 1'b1));

  p_count_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !slipStep |=> $stable(slipCount));

  p_wrap_point_r5: assert property (@(posedge clk) disable iff (rst)
    wrapStep |-> slipCount == LAST_OFS);

  p_count_range_r5: assert property (@(posedge clk) disable iff (rst)
    slipCount <= LAST_OFS);

  p_mode_ignore_r6: assert property (@(posedge clk) disable iff (rst)
    !bitslipEn |=> $stable(slipCount));

  p_long_ones_r7: assert property (@(posedge clk) disable iff (rst)
    (rxWord == '1 && RUN_LIMIT < WORD_W) |=> runErr);

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (slipCount == '0 && !runErr && dataOut == '0));

endmodule

bind bitslip_aligner bitslip_aligner_chk #(
  .WORD_W    (WORD_W),
  .RUN_LIMIT (RUN_LIMIT),
  .SLIP_W    (SLIP_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bitslipEn (bitslipEn),
  .rxWord    (rxWord),
  .dataOut   (dataOut),
  .slipCount (slipCount),
  .runErr    (runErr),
  .slipStep  (strobe.slipStep),
  .wrapStep  (strobe.wrapStep),
  .dpSel     (dpSel)
);

// File: tb/bitslip_aligner_test.sv
`timescale 1ns/1ps
module bitslip_aligner_test;

  localparam int W     = 20;
  localparam int LIMIT = 16;
  localparam int SW    = $clog2(W);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  rxWord = '0;
  logic          slipReq = 1'b0;
  logic          bitslipEn = 1'b1;
  logic [W-1:0]  dataOut;
  logic [SW-1:0] slipCount;
  logic          runErr;

  int total = 0;
  int fails = 0;
  int expCount = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bitslip_aligner #(.WORD_W(W), .RUN_LIMIT(LIMIT)) uut (
    .clk(clk), .rst(rst), .rxWord(rxWord), .slipReq(slipReq),
    .bitslipEn(bitslipEn), .dataOut(dataOut), .slipCount(slipCount),
    .runErr(runErr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [W-1:0]   m1, m2, mOut;
  logic [2*W-1:0] win;
  int             mCnt, run;
  bit             r0, r1, r2, mErr, lb, pulse, valid;

  initial valid = 0;

  always @(posedge clk) begin
    if (rst) begin
      m1 = '0; m2 = '0; mOut = '0; mCnt = 0; run = 0; lb = 0;
      r0 = 0; r1 = 0; r2 = 0; mErr = 0;
    end else begin
      pulse = r1 && !r2 && bitslipEn;
      win   = {m1, m2};
      mOut  = W'(win >> mCnt);
      m2 = m1;
      m1 = rxWord;
      mErr = 0;
      for (int i = 0; i < W; i++) begin
        if (run > 0 && rxWord[i] == lb) run++;
        else begin run = 1; lb = rxWord[i]; end
        if (run > LIMIT) mErr = 1;
      end
      if (pulse) mCnt = (mCnt == W - 1) ? 0 : mCnt + 1;
      r2 = r1; r1 = r0; r0 = slipReq;
    end
    valid = 1;
  end

  // Per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (valid && !finished) begin
      chk(dataOut == mOut, "R2 model dataOut", 32'(dataOut), 32'(mOut));
      chk(int'(slipCount) == mCnt, "R4 model slipCount", 32'(slipCount), 32'(mCnt));
      chk(runErr == mErr, "R7 model runErr", 32'(runErr), 32'(mErr));
    end
  end

  task automatic stepRand();
    @(negedge clk);
    rxWord = W'($urandom);
  endtask

  task automatic stepWord(input logic [W-1:0] w);
    @(negedge clk);
    rxWord = w;
  endtask

  task automatic doSlip();
    slipReq = 1'b1;
    repeat (4) stepRand();
    slipReq = 1'b0;
    repeat (4) stepRand();
    if (bitslipEn) expCount = (expCount + 1) % W;
  endtask

  logic [W-1:0] seq [8];
  bit           seqErr [8];
  logic [W-1:0] wa, wb;

  initial begin
    repeat (3) stepRand();
    rst = 1'b0;
    // R9: reset state
    chk(slipCount == '0 && !runErr && dataOut == '0, "R9 reset state", 32'(slipCount), 0);
    chk($bits(slipCount) == 5, "R4 count width", $bits(slipCount), 5);

    // R8: two-edge latency at slip 0
    wa = 20'h5A3C1;
    stepWord(wa); stepRand(); stepRand(); stepRand();
    chk(dataOut == wa, "R8 latency", 32'(dataOut), 32'(wa));

    // R3 synchronizer timing, then R1 held level
    slipReq = 1'b1;
    stepRand(); stepRand();
    chk(int'(slipCount) == 0, "R3 no early slip", 32'(slipCount), 0);
    stepRand();
    chk(int'(slipCount) == 1, "R3 slip after third edge", 32'(slipCount), 1);
    repeat (10) stepRand();
    chk(int'(slipCount) == 1, "R1 held level one slip", 32'(slipCount), 1);
    slipReq = 1'b0;
    repeat (4) stepRand();
    expCount = 1;

    // R2 at offset 1: newer bit 0 enters at the top
    wa = 20'h12345; wb = 20'h6789B;
    stepWord(wa); stepWord(wb); stepRand(); stepRand();
    chk(dataOut == {wb[0], wa[W-1:1]}, "R2 drop oldest bit", 32'(dataOut), 32'({wb[0], wa[W-1:1]}));

    // R6: mode low ignores requests
    bitslipEn = 1'b0;
    repeat (3) doSlip();
    chk(int'(slipCount) == expCount, "R6 ignored when disabled", 32'(slipCount), 32'(expCount));
    bitslipEn = 1'b1;

    // R4 and R5: count up to the last offset, then wrap
    while (expCount != W - 1) doSlip();
    chk(int'(slipCount) == W - 1, "R4 cumulative count", 32'(slipCount), W - 1);
    doSlip();
    chk(int'(slipCount) == 0, "R5 wrap to zero", 32'(slipCount), 0);
    wa = 20'hC0FFE;
    stepWord(wa); stepRand(); stepRand(); stepRand();
    chk(dataOut == wa, "R5 original offset restored", 32'(dataOut), 32'(wa));

    // R7 boundary sequence
    seq[0] = 20'hAAAAA; seqErr[0] = 0;
    seq[1] = 20'h0000F; seqErr[1] = 0;  // run of exactly LIMIT zeros
    seq[2] = 20'h55555; seqErr[2] = 0;
    seq[3] = 20'h00007; seqErr[3] = 1;  // LIMIT+1 zeros
    seq[4] = 20'h55555; seqErr[4] = 0;
    seq[5] = 20'hFFF00; seqErr[5] = 0;
    seq[6] = 20'h0003F; seqErr[6] = 1;  // ones run spanning a word edge
    seq[7] = 20'hAAAAA; seqErr[7] = 0;
    for (int k = 0; k < 8; k++) begin
      stepWord(seq[k]);
      if (k >= 2) chk(runErr == seqErr[k-1], "R7 run limit", 32'(runErr), 32'(seqErr[k-1]));
    end
    stepRand();
    chk(runErr == seqErr[7], "R7 run limit", 32'(runErr), 32'(seqErr[7]));

    // Random phase: slips, mode toggles and long runs together
    for (int n = 0; n < 300; n++) begin
      int hold, gap, kind;
      hold = 1 + ($urandom % 5);
      gap  = 1 + ($urandom % 5);
      if (($urandom % 8) == 0) bitslipEn = ~bitslipEn;
      slipReq = 1'b1;
      for (int h = 0; h < hold; h++) begin
        kind = $urandom % 4;
        if (kind == 0) stepWord('1);
        else if (kind == 1) stepWord('0);
        else stepRand();
      end
      slipReq = 1'b0;
      for (int g = 0; g < gap; g++) stepRand();
    end
    bitslipEn = 1'b1;

    // R9: reset in mid-run
    slipReq = 1'b1;
    stepWord('1);
    rst = 1'b1;
    stepRand();
    stepRand();
    chk(slipCount == '0 && !runErr && dataOut == '0, "R9 mid-run reset", 32'(slipCount), 0);
    slipReq = 1'b0;
    rst = 1'b0;
    repeat (6) stepRand();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
      $finish;
    end
  end

endmodule